// File: doc/BRIEF.md
# Clock Divider Triple Search Engine

This block takes a requested output clock frequency and finds the divider setting that a PLL of the form `out = f_ref * N / (M * P)` should be programmed with. The request is first pulled into the legal range. The engine then tries every allowed post divider P and every reference divider M in a fixed window. For each pair it works out a rounded feedback divider N and keeps the setting whose output lies closest to the request. All frequencies are unsigned fixed-point values in MHz with 16 fractional bits.

A single-cycle `start_i` pulse samples the request and the limits and begins the search. A single-cycle `done_o` pulse ends it. When `done_o` is high, the packed programming word, the post-divider code and the achieved frequency are valid, and they hold their values until the next search ends. The division inside the N computation and the one for the achieved frequency run on one shared serial divider, so each candidate takes several tens of cycles.

Top module: `pll_div_search`

## Requirements
- R1: When a search starts, a request below `vco_min_i >> 4` (fixed-point value, truncated) is raised to that value before the search begins.
- R2: After R1 has been applied, a request above `pclk_max_i` is lowered to `pclk_max_i`.
- R3: P is tried in ascending order 1, 2, 4, 8, 16. A value of P is used only when `request * P` lies inside `[vco_min_i, vco_max_i]` inclusive.
- R4: For each P that is used, M runs from 7 to 14 in ascending order. M is used only when `f_ref / M` lies inside 1.0 to 2.0 MHz inclusive, which means `M * 1.0 <= f_ref <= M * 2.0`.
- R5: N is `request * P * M / f_ref` rounded half up, computed as `floor((2*request*P*M + f_ref) / (2*f_ref))`. A candidate with N outside 1..255 is dropped.
- R6: The error of a candidate is `|request - f_ref*N/(M*P)|`, compared exactly. A candidate replaces the stored best only when its error is strictly smaller, so among equal errors the first one found is kept.
- R7: `pcode_o` is log2(P), so 1→0, 2→1, 4→2, 8→3 and 16→4. `word_o` packs `pcode_o` in bits 18:16, N in bits 15:8 and M in bits 7:0.
- R8: `freq_o` is `floor(f_ref * N / (M * P))` for the chosen triple.
- R9: When no candidate passes every check, `found_o` is low and `word_o`, `pcode_o` and `freq_o` are zero.
- R10: Each accepted start gives exactly one single-cycle `done_o` pulse. A start that arrives while a search is running is ignored.
- R11: After reset, `done_o` and `found_o` are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle pulse that samples the inputs and starts a search |
| req_i | input | 32 | Requested frequency, 16.16 MHz |
| fref_i | input | 32 | Reference frequency, 16.16 MHz |
| vco_min_i | input | 32 | Lowest legal VCO frequency, 16.16 MHz |
| vco_max_i | input | 32 | Highest legal VCO frequency, 16.16 MHz |
| pclk_max_i | input | 32 | Highest allowed output frequency, 16.16 MHz |
| done_o | output | 1 | Single-cycle pulse when a search ends |
| found_o | output | 1 | A valid triple was found |
| word_o | output | 19 | Packed programming word {P code, N, M} |
| pcode_o | output | 3 | log2 of the chosen post divider |
| freq_o | output | 32 | Achieved output frequency, 16.16 MHz |

## Verification
Two things can land in the same window: a new start request and a search that is still running, which includes its last divide. The bench provokes this by sending a second start pulse with a different request partway through a search. It then checks that the one `done_o` that follows carries the result computed for the first request, and that no second pulse appears for thousands of cycles afterwards. A second overlap is between equal-error candidates, where a replacement competes with an earlier entry. Directed cases with exact frequency ties check that the first one found wins.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PCHK  = 3'd1,
        S_MCHK  = 3'd2,
        S_NWAIT = 3'd3,
        S_AWAIT = 3'd4
    } srch_st_e;

endpackage

// File: rtl/pll_div_seq.sv
module pll_div_seq #(
    parameter int DW = 42,
    parameter int SW = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [DW-1:0] dvd_i,
    input  logic [SW-1:0] dvs_i,
    output logic          done_o,
    output logic [DW-1:0] quo_o
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW-1:0] dvd;
        logic [SW-1:0] dvs;
        logic [SW:0]   rem;
        logic [DW-1:0] quo;
    } div_t;

    div_t q, d;
    logic [SW:0] rem_sh;
    logic        qbit;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = {q.rem[SW-1:0], q.dvd[DW-1]};
        qbit   = 1'b0;
        if (q.busy) begin
            if (rem_sh >= {1'b0, q.dvs}) begin
                d.rem = rem_sh - {1'b0, q.dvs};
                qbit  = 1'b1;
            end else begin
                d.rem = rem_sh;
            end
            d.quo = {q.quo[DW-2:0], qbit};
            d.dvd = q.dvd << 1;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CW'(DW - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end else if (go_i) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.dvd  = dvd_i;
            d.dvs  = dvs_i;
            d.rem  = '0;
            d.quo  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quo_o  = q.quo;

    // R5 / R8: the remainder left by a finished divide is below the divisor
    p_div_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.rem < {1'b0, q.dvs}));

endmodule

// File: rtl/pll_cand_cmp.sv
module pll_cand_cmp #(
    parameter int FW  = 32,
    parameter int MW  = 4,
    parameter int NW  = 8,
    parameter int PIW = 3,
    parameter int EW  = 44,
    parameter int DNW = 8
) (
    input  logic [FW-1:0]  req_i,
    input  logic [FW-1:0]  fref_i,
    input  logic [MW-1:0]  m_i,
    input  logic [PIW-1:0] sh_i,
    input  logic [NW-1:0]  n_i,
    input  logic [EW-1:0]  best_err_i,
    input  logic [DNW-1:0] best_den_i,
    output logic [EW-1:0]  err_o,
    output logic [DNW-1:0] den_o,
    output logic           better_o
);
    localparam int CW = EW + DNW;

    logic [EW-1:0] lhs, rhs;

    // error scaled by M*P: |req*M*P - f_ref*N|, denominator M*P kept alongside
    always_comb begin
        lhs      = (EW'(req_i) * EW'(m_i)) << sh_i;
        rhs      = EW'(fref_i) * EW'(n_i);
        err_o    = (lhs >= rhs) ? (lhs - rhs) : (rhs - lhs);
        den_o    = DNW'(m_i) << sh_i;
        better_o = (CW'(err_o) * CW'(best_den_i)) < (CW'(best_err_i) * CW'(den_o));
    end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_srch_pkg::*;
#(
    parameter int FW      = 32,
    parameter int FRAC    = 16,
    parameter int NP      = 5,
    parameter int M_LO    = 7,
    parameter int M_HI    = 14,
    parameter int NW      = 8,
    parameter int MFW     = 8,
    parameter int DISC_LO = 1,
    parameter int DISC_HI = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [FW-1:0]                 req_i,
    input  logic [FW-1:0]                 fref_i,
    input  logic [FW-1:0]                 vco_min_i,
    input  logic [FW-1:0]                 vco_max_i,
    input  logic [FW-1:0]                 pclk_max_i,
    output logic                          done_o,
    output logic                          found_o,
    output logic [$clog2(NP+1)+NW+MFW-1:0] word_o,
    output logic [$clog2(NP+1)-1:0]       pcode_o,
    output logic [FW-1:0]                 freq_o
);
    localparam int PIW   = $clog2(NP + 1);
    localparam int MW    = $clog2(M_HI + 2);
    localparam int VW    = FW + NP - 1;
    localparam int DW    = VW + MW + 2;
    localparam int SW    = FW + 1;
    localparam int EW    = FW + NW + MW;
    localparam int DNW   = MW + NP - 1;
    localparam int WW    = PIW + NW + MFW;
    localparam int XW    = FW + MW + 4;
    localparam int NMAX  = (1 << NW) - 1;
    localparam int LOSH  = NP - 1;
    localparam int PSLOT = 1 << PIW;

    typedef struct packed {
        srch_st_e       st;
        logic [FW-1:0]  req;
        logic [FW-1:0]  fref;
        logic [FW-1:0]  vmin;
        logic [FW-1:0]  vmax;
        logic [FW-1:0]  pmax;
        logic [PIW-1:0] pidx;
        logic [MW-1:0]  m;
        logic           have;
        logic [MW-1:0]  bm;
        logic [NW-1:0]  bn;
        logic [PIW-1:0] bp;
        logic [EW-1:0]  berr;
        logic [DNW-1:0] bden;
        logic           done;
        logic           found;
        logic [WW-1:0]  word;
        logic [PIW-1:0] pcode;
        logic [FW-1:0]  freq;
    } eng_t;

    eng_t q, d;

    logic [PSLOT-1:0] vco_ok;
    logic [VW-1:0]    vco_cur;
    logic             disc_ok;
    logic             div_go;
    logic [DW-1:0]    div_num;
    logic [SW-1:0]    div_den;
    logic             div_done;
    logic [DW-1:0]    div_quo;
    logic             n_ok;
    logic [EW-1:0]    c_err;
    logic [DNW-1:0]   c_den;
    logic             c_better;
    logic [FW-1:0]    clamp_req;

    // window test for every post divider, one slot per P
    for (genvar g = 0; g < PSLOT; g++) begin : g_pwin
        if (g < NP) begin : g_used
            assign vco_ok[g] = ((VW'(q.req) << g) >= VW'(q.vmin)) &&
                               ((VW'(q.req) << g) <= VW'(q.vmax));
        end else begin : g_pad
            assign vco_ok[g] = 1'b0;
        end
    end

    assign vco_cur = VW'(q.req) << q.pidx;
    assign disc_ok = (XW'(q.fref) >= ((XW'(q.m) * XW'(DISC_LO)) << FRAC)) &&
                     (XW'(q.fref) <= ((XW'(q.m) * XW'(DISC_HI)) << FRAC));
    assign n_ok    = (div_quo >= DW'(1)) && (div_quo <= DW'(NMAX));

    always_comb begin
        clamp_req = req_i;
        if (clamp_req < (vco_min_i >> LOSH)) clamp_req = vco_min_i >> LOSH;
        if (clamp_req > pclk_max_i)          clamp_req = pclk_max_i;
    end

    pll_cand_cmp #(
        .FW(FW), .MW(MW), .NW(NW), .PIW(PIW), .EW(EW), .DNW(DNW)
    ) u_cmp (
        .req_i      (q.req),
        .fref_i     (q.fref),
        .m_i        (q.m),
        .sh_i       (q.pidx),
        .n_i        (div_quo[NW-1:0]),
        .best_err_i (q.berr),
        .best_den_i (q.bden),
        .err_o      (c_err),
        .den_o      (c_den),
        .better_o   (c_better)
    );

    pll_div_seq #(.DW(DW), .SW(SW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .dvd_i  (div_num),
        .dvs_i  (div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.req  = clamp_req;
                    d.fref = fref_i;
                    d.vmin = vco_min_i;
                    d.vmax = vco_max_i;
                    d.pmax = pclk_max_i;
                    d.pidx = '0;
                    d.m    = '0;
                    d.have = 1'b0;
                    d.bm   = '0;
                    d.bn   = '0;
                    d.bp   = '0;
                    d.berr = '0;
                    d.bden = '0;
                    d.st   = S_PCHK;
                end
            end
            S_PCHK: begin
                if (q.pidx == PIW'(NP)) begin
                    if (q.have) begin
                        div_go  = 1'b1;
                        div_num = DW'(q.bn) * DW'(q.fref);
                        div_den = SW'(q.bm) << q.bp;
                        d.st    = S_AWAIT;
                    end else begin
                        d.done  = 1'b1;
                        d.found = 1'b0;
                        d.word  = '0;
                        d.pcode = '0;
                        d.freq  = '0;
                        d.st    = S_IDLE;
                    end
                end else if (vco_ok[q.pidx]) begin
                    d.m  = MW'(M_LO);
                    d.st = S_MCHK;
                end else begin
                    d.pidx = q.pidx + 1'b1;
                end
            end
            S_MCHK: begin
                if (q.m > MW'(M_HI)) begin
                    d.pidx = q.pidx + 1'b1;
                    d.st   = S_PCHK;
                end else if (disc_ok) begin
                    div_go  = 1'b1;
                    div_num = ((DW'(vco_cur) * DW'(q.m)) << 1) + DW'(q.fref);
                    div_den = SW'(q.fref) << 1;
                    d.st    = S_NWAIT;
                end else begin
                    d.m = q.m + 1'b1;
                end
            end
            S_NWAIT: begin
                if (div_done) begin
                    if (n_ok && (!q.have || c_better)) begin
                        d.have = 1'b1;
                        d.bm   = q.m;
                        d.bn   = div_quo[NW-1:0];
                        d.bp   = q.pidx;
                        d.berr = c_err;
                        d.bden = c_den;
                    end
                    d.m  = q.m + 1'b1;
                    d.st = S_MCHK;
                end
            end
            S_AWAIT: begin
                if (div_done) begin
                    d.done  = 1'b1;
                    d.found = 1'b1;
                    d.word  = {q.bp, q.bn, MFW'(q.bm)};
                    d.pcode = q.bp;
                    d.freq  = FW'(div_quo);
                    d.st    = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o  = q.done;
    assign found_o = q.found;
    assign word_o  = q.word;
    assign pcode_o = q.pcode;
    assign freq_o  = q.freq;

    p_clamp_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PCHK) |-> ((q.req >= (q.vmin >> LOSH)) || (q.req == q.pmax)));

    p_clamp_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |-> (q.req <= q.pmax));

    p_pcode_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.found) |-> (q.pcode < PIW'(NP)));

    p_disc_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_NWAIT) |-> ((q.m >= MW'(M_LO)) && (q.m <= MW'(M_HI)) &&
                               (XW'(q.fref) >= (XW'(q.m) << FRAC))));

    p_word_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.found) |-> ((q.word[WW-1 -: PIW] == q.pcode) &&
                                 (q.word[MFW-1:0] >= MFW'(M_LO)) &&
                                 (q.word[MFW-1:0] <= MFW'(M_HI)) &&
                                 (q.word[MFW +: NW] != '0)));

    p_lost_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && !q.found) |-> ((q.word == '0) && (q.freq == '0) && (q.pcode == '0)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != S_IDLE) && start_i) |=> $stable(q.req));

endmodule

// File: tb/pll_div_search_tb.sv
`timescale 1ns/1ps
module pll_div_search_tb;

    localparam longint unsigned ONE = 64'd65536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req = '0, fref = '0, vmin = '0, vmax = '0, pmax = '0;
    logic        done, found;
    logic [18:0] word;
    logic [2:0]  pcode;
    logic [31:0] freq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pll_div_search u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .req_i(req), .fref_i(fref), .vco_min_i(vmin), .vco_max_i(vmax),
        .pclk_max_i(pmax), .done_o(done), .found_o(found), .word_o(word),
        .pcode_o(pcode), .freq_o(freq)
    );

    task automatic check(input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model(input longint unsigned r_in, input longint unsigned fr,
                         input longint unsigned mn, input longint unsigned mx,
                         input longint unsigned pm,
                         output bit f, output longint unsigned w,
                         output longint unsigned pc, output longint unsigned ach);
        longint unsigned r, v, n, e, den, be, bd, bm, bn, bp, lhs, rhs;
        r = r_in;
        if (r < (mn >> 4)) r = mn >> 4;
        if (r > pm) r = pm;
        f = 0; be = 0; bd = 1; bm = 0; bn = 0; bp = 0;
        for (int p = 0; p < 5; p++) begin
            v = r << p;
            if (v < mn || v > mx) continue;
            for (int m = 7; m <= 14; m++) begin
                if (fr < m * ONE || fr > m * 2 * ONE) continue;
                n = (2 * v * m + fr) / (2 * fr);
                if (n < 1 || n > 255) continue;
                lhs = (r * m) << p;
                rhs = fr * n;
                e   = (lhs >= rhs) ? lhs - rhs : rhs - lhs;
                den = m << p;
                if (!f || (e * bd < be * den)) begin
                    f = 1; be = e; bd = den; bm = m; bn = n; bp = p;
                end
            end
        end
        if (f) begin
            w   = (bp << 16) | (bn << 8) | bm;
            pc  = bp;
            ach = (fr * bn) / (bm << bp);
        end else begin
            w = 0; pc = 0; ach = 0;
        end
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (done !== 1'b1 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (done !== 1'b1) begin
            checks++; fails++;
            $display("FAIL %s timeout: actual no done expected done", tag);
        end
    endtask

    task automatic run(input string tag, input longint unsigned r, input longint unsigned fr,
                       input longint unsigned mn, input longint unsigned mx,
                       input longint unsigned pm);
        bit f; longint unsigned w, pc, ach;
        model(r, fr, mn, mx, pm, f, w, pc, ach);
        @(negedge clk);
        req = 32'(r); fref = 32'(fr); vmin = 32'(mn); vmax = 32'(mx); pmax = 32'(pm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(tag);
        check(tag, "found", found, f);
        check(tag, "word",  word,  w);
        check(tag, "pcode", pcode, pc);
        check(tag, "freq",  freq,  ach);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        bit f; longint unsigned w, pc, ach, r0, r1;
        int seen;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "done",  done,  0);
        check("R11", "found", found, 0);
        check("R11", "word",  word,  0);
        check("R11", "freq",  freq,  0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: exact tie, 14 MHz ref, 100 MHz: M=7 N=50 P=1 is first
        run("R6", 100 * ONE, 14 * ONE, 90 * ONE, 400 * ONE, 300 * ONE);
        check("R6", "first tie word", word, (0 << 16) | (50 << 8) | 7);
        check("R8", "tie freq", freq, 100 * ONE);

        // R5: half-up rounding, 7 MHz ref, only M=7 and P=1 usable, 100.5 MHz -> N=101
        run("R5", 100 * ONE + ONE / 2, 7 * ONE, 90 * ONE, 150 * ONE, 300 * ONE);
        check("R5", "rounded N", (word >> 8) & 8'hFF, 101);
        check("R8", "rounded freq", freq, 101 * ONE);

        // R5: N above 255 dropped, nothing left -> R9
        run("R5", 300 * ONE, 7 * ONE, 100 * ONE, 400 * ONE, 350 * ONE);
        check("R9", "no triple found", found, 0);

        // R3: only P=4 puts the VCO in 190..210 MHz
        run("R3", 50 * ONE, 14 * ONE, 190 * ONE, 210 * ONE, 300 * ONE);
        check("R3", "P code", pcode, 2);
        check("R7", "P field", word >> 16, 2);

        // R4: 40 MHz reference leaves no M in the 1..2 MHz window -> R9
        run("R4", 100 * ONE, 40 * ONE, 90 * ONE, 400 * ONE, 300 * ONE);
        check("R9", "zero word", word, 0);

        // R1: request below min/16 is treated as min/16
        run("R1", 1 * ONE, 27 * ONE, 200 * ONE + 12345, 400 * ONE, 300 * ONE);
        model((200 * ONE + 12345) >> 4, 27 * ONE, 200 * ONE + 12345, 400 * ONE, 300 * ONE,
              f, w, pc, ach);
        check("R1", "raised request word", word, w);

        // R2: request above max is treated as max
        run("R2", 390 * ONE, 27 * ONE, 150 * ONE, 400 * ONE, 123 * ONE + 777);
        model(123 * ONE + 777, 27 * ONE, 150 * ONE, 400 * ONE, 123 * ONE + 777, f, w, pc, ach);
        check("R2", "lowered request word", word, w);

        // R10: second start while busy is ignored
        r0 = 77 * ONE + 4321; r1 = 133 * ONE;
        model(r0, 25 * ONE, 150 * ONE, 350 * ONE, 300 * ONE, f, w, pc, ach);
        @(negedge clk);
        req = 32'(r0); fref = 32'(25 * ONE); vmin = 32'(150 * ONE);
        vmax = 32'(350 * ONE); pmax = 32'(300 * ONE);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        req = 32'(r1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10");
        check("R10", "first request word", word, w);
        check("R10", "first request freq", freq, ach);
        @(negedge clk);
        check("R10", "done width", done, 0);
        seen = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        check("R10", "extra done pulses", seen, 0);

        // R8 / R7 / R3 / R4 / R6: seeded random sweep against the model
        void'($urandom(32'd20240611));
        for (int k = 0; k < 30; k++) begin
            longint unsigned rr, ff, mn, mx, pm;
            ff = ((7 + $urandom % 22) * ONE) + ($urandom % ONE);
            mn = ((80 + $urandom % 80) * ONE) + ($urandom % ONE);
            mx = mn + ((100 + $urandom % 200) * ONE);
            pm = ((50 + $urandom % 300) * ONE) + ($urandom % ONE);
            rr = ($urandom % 400) * ONE + ($urandom % ONE);
            run("R8", rr, ff, mn, mx, pm);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule